// File: doc/BRIEF.md
# Half-Rate Pair Output with Framing Alignment and Odd Parity

This block is the last stage of a receive path. Decoded characters come in at character rate, one per clock when `in_valid` is high. Each character has eight data bits, three status bits and a flag that marks a framing character. The block packs the characters two at a time into an output pair. The first character of a pair goes to the even slot, which is the rising-edge slot of the half-rate output. The second goes to the odd slot, which is the falling-edge slot. A one-cycle `out_valid` strobe marks each completed pair.

When `framer_en` is high, a framing character must never leave in the odd slot. If one arrives while an even character is already waiting, the waiting character is dropped. The framing character then starts a new pair. Latency shifts by one character, and everything after the slip point stays in order. When `framer_en` is low, no realignment happens.

The block also conditions status bit 2 when the decoder is bypassed. For each output slot it produces an odd-parity bit over a selectable set of bits, together with an output-enable that stands in for a tri-state driver.

Top module: `rxo_pair_out`

## Requirements
- R1: While reset is held, and after it is released until a pair completes, `out_valid` is 0, all slot data, status and frame outputs are 0, and with `par_mode`=00 `par_oe` is 0.
- R2: Two accepted characters form a pair, the first in the even slot and the second in the odd slot. `out_valid` pulses high for exactly one cycle, in the cycle after the clock edge that accepts the second character.
- R3: Cycles with `in_valid` low are ignored. Slot outputs keep their last pair until the next pair completes, and a gap between the two characters of a pair does not break the pair.
- R4: With `framer_en`=1, a framing character (`in_frame`=1) accepted in the odd position discards the pending even character and becomes the even character of a new pair. Later characters follow in order.
- R5: With `framer_en`=1, a framing character accepted in the even position is paired normally with the next character.
- R6: With `framer_en`=0, a framing character accepted in the odd position leaves in the odd slot with `odd_frame`=1.
- R7: Each slot's frame flag is the `in_frame` value of the character in that slot.
- R8: When `dec_bypass`=1, `bist_active`=0 and the character is not a framing character, its status bit 2 is output as 0. Otherwise the status passes through unchanged.
- R9: `par_mode` 00 (off) and 11 (treated as off) drive `par_oe`=0 and both parity bits to 0.
- R10: `par_mode` 01 with `dec_bypass`=0 sets each slot's parity bit so that data[7:0] plus the parity bit hold an odd number of ones.
- R11: `par_mode` 01 with `dec_bypass`=1 gives odd parity over data[7:0] and status[1:0].
- R12: `par_mode` 10 gives odd parity over data[7:0] and the output status[2:0], and drives `par_oe`=1 (as `par_mode` 01 also does).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input character strobe |
| in_data | input | 8 | Decoded character data |
| in_stat | input | 3 | Character status |
| in_frame | input | 1 | Character is the selected framing character |
| framer_en | input | 1 | Enable even-slot framing alignment |
| dec_bypass | input | 1 | Decoder bypassed (selects parity coverage and status forcing) |
| bist_active | input | 1 | Receive self-test is active (blocks status forcing) |
| par_mode | input | 2 | Parity control: 00 off, 01 mid, 10 high, 11 off |
| out_valid | output | 1 | One-cycle strobe for a new pair |
| even_data | output | 8 | Even-slot data |
| even_stat | output | 3 | Even-slot status |
| even_frame | output | 1 | Even-slot framing flag |
| odd_data | output | 8 | Odd-slot data |
| odd_stat | output | 3 | Odd-slot status |
| odd_frame | output | 1 | Odd-slot framing flag |
| even_par | output | 1 | Even-slot odd-parity bit |
| odd_par | output | 1 | Odd-slot odd-parity bit |
| par_oe | output | 1 | Parity output enable (low = high impedance) |

## Verification
The assertions assume that `framer_en`, `dec_bypass` and `bist_active` hold steady between the acceptance of a pair's odd character and the following clock. The framing and status properties read these inputs one cycle in the past, so this is what lets them tie an emitted character to the mode it was accepted under. The bench changes these controls only while `in_valid` is low and a whole pair has drained. The parity properties assume `par_mode` is compared against the current slot contents. The bench therefore changes `par_mode` and `dec_bypass` only on falling edges, while the output registers are holding a finished pair. Framing characters are placed at both even and odd positions, with the framer both on and off.

// File: rtl/rxo_pkg.sv
package rxo_pkg;
  parameter int DATA_W = 8;
  parameter int STAT_W = 3;
  localparam int MID_STAT_W = STAT_W - 1;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [STAT_W-1:0] stat;
    logic              frame;
  } char_t;

  typedef enum logic [1:0] {
    PM_OFF  = 2'b00,
    PM_MID  = 2'b01,
    PM_HIGH = 2'b10,
    PM_RSV  = 2'b11
  } pmode_t;
endpackage

// File: rtl/rxo_stat_cond.sv
module rxo_stat_cond
  import rxo_pkg::*;
(
  input  char_t raw_ch,
  input  logic  dec_bypass,
  input  logic  bist_active,
  output char_t cond_ch
);
  logic force_top;

  // Top status bit is cleared for bypassed, non-self-test, non-framing chars
  assign force_top = dec_bypass && !bist_active && !raw_ch.frame;

  always_comb begin
    cond_ch = raw_ch;
    if (force_top) begin
      cond_ch.stat[STAT_W-1] = 1'b0;
    end
  end
endmodule

// File: rtl/rxo_par_gen.sv
module rxo_par_gen
  import rxo_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [STAT_W-1:0] stat,
  input  pmode_t            mode,
  input  logic              dec_bypass,
  output logic              par
);
  always_comb begin
    case (mode)
      PM_MID: begin
        if (dec_bypass) par = ~^{data, stat[MID_STAT_W-1:0]};
        else            par = ~^data;
      end
      PM_HIGH: par = ~^{data, stat};
      default: par = 1'b0;
    endcase
  end
endmodule

// File: rtl/rxo_slot_align.sv
module rxo_slot_align
  import rxo_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  in_valid,
  input  char_t in_ch,
  input  logic  framer_en,
  output logic  out_valid,
  output char_t even_ch,
  output char_t odd_ch
);
  logic  phase_q, phase_d;
  char_t hold_q, hold_d;
  char_t even_q, even_d;
  char_t odd_q, odd_d;
  logic  vld_q, vld_d;
  logic  slip, take_even, emit;

  // Next-state logic
  always_comb begin
    slip      = in_valid && phase_q && framer_en && in_ch.frame;
    take_even = in_valid && (!phase_q || slip);
    emit      = in_valid && phase_q && !slip;

    phase_d = phase_q;
    if (in_valid) phase_d = slip ? 1'b1 : ~phase_q;

    hold_d = hold_q;
    if (take_even) hold_d = in_ch;

    even_d = even_q;
    odd_d  = odd_q;
    if (emit) begin
      even_d = hold_q;
      odd_d  = in_ch;
    end
    vld_d = emit;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      hold_q  <= '0;
      even_q  <= '0;
      odd_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      vld_q   <= vld_d;
      if (take_even) hold_q <= hold_d;
      if (emit) begin
        even_q <= even_d;
        odd_q  <= odd_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign even_ch   = even_q;
  assign odd_ch    = odd_q;
endmodule

// File: rtl/rxo_pair_out.sv
module rxo_pair_out
  import rxo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [STAT_W-1:0] in_stat,
  input  logic              in_frame,
  input  logic              framer_en,
  input  logic              dec_bypass,
  input  logic              bist_active,
  input  logic [1:0]        par_mode,
  output logic              out_valid,
  output logic [DATA_W-1:0] even_data,
  output logic [STAT_W-1:0] even_stat,
  output logic              even_frame,
  output logic [DATA_W-1:0] odd_data,
  output logic [STAT_W-1:0] odd_stat,
  output logic              odd_frame,
  output logic              even_par,
  output logic              odd_par,
  output logic              par_oe
);
  localparam int SLOTS = 2;

  logic   rst_meta_q, rst_sync_q;
  char_t  raw_ch, cond_ch, even_ch, odd_ch;
  pmode_t pmode;
  char_t  slot_ch  [SLOTS];
  logic   slot_par [SLOTS];

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign raw_ch = '{data: in_data, stat: in_stat, frame: in_frame};
  assign pmode  = pmode_t'(par_mode);

  rxo_stat_cond u_cond (
    .raw_ch      (raw_ch),
    .dec_bypass  (dec_bypass),
    .bist_active (bist_active),
    .cond_ch     (cond_ch)
  );

  rxo_slot_align u_align (
    .clk       (clk),
    .rst_ni    (rst_sync_q),
    .in_valid  (in_valid),
    .in_ch     (cond_ch),
    .framer_en (framer_en),
    .out_valid (out_valid),
    .even_ch   (even_ch),
    .odd_ch    (odd_ch)
  );

  assign slot_ch[0] = even_ch;
  assign slot_ch[1] = odd_ch;

  for (genvar g = 0; g < SLOTS; g++) begin : g_par
    rxo_par_gen u_par (
      .data       (slot_ch[g].data),
      .stat       (slot_ch[g].stat),
      .mode       (pmode),
      .dec_bypass (dec_bypass),
      .par        (slot_par[g])
    );
  end

  assign par_oe     = (pmode == PM_MID) || (pmode == PM_HIGH);
  assign even_data  = even_ch.data;
  assign even_stat  = even_ch.stat;
  assign even_frame = even_ch.frame;
  assign odd_data   = odd_ch.data;
  assign odd_stat   = odd_ch.stat;
  assign odd_frame  = odd_ch.frame;
  assign even_par   = slot_par[0];
  assign odd_par    = slot_par[1];
endmodule

// File: rtl/rxo_pair_out_chk.sv
module rxo_pair_out_chk
  import rxo_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              framer_en,
  input logic              dec_bypass,
  input logic              bist_active,
  input logic [1:0]        par_mode,
  input logic              out_valid,
  input logic [DATA_W-1:0] even_data,
  input logic [STAT_W-1:0] even_stat,
  input logic              even_frame,
  input logic [DATA_W-1:0] odd_data,
  input logic [STAT_W-1:0] odd_stat,
  input logic              odd_frame,
  input logic              even_par,
  input logic              odd_par,
  input logic              par_oe
);
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R2

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable({even_data, even_stat, even_frame, odd_data, odd_stat, odd_frame})); // R3

  AST_FRAME_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(framer_en) |-> !odd_frame); // R4

  AST_ST2_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(dec_bypass) && !$past(bist_active) && !odd_frame |-> !odd_stat[STAT_W-1]); // R8

  AST_PAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (par_mode == 2'b00 || par_mode == 2'b11) |-> (!par_oe && !even_par && !odd_par)); // R9

  AST_PAR_HIGH_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode == 2'b10 |-> (par_oe && (^{even_data, even_stat, even_par}) && (^{odd_data, odd_stat, odd_par}))); // R12
endmodule

bind rxo_pair_out rxo_pair_out_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .framer_en   (framer_en),
  .dec_bypass  (dec_bypass),
  .bist_active (bist_active),
  .par_mode    (par_mode),
  .out_valid   (out_valid),
  .even_data   (even_data),
  .even_stat   (even_stat),
  .even_frame  (even_frame),
  .odd_data    (odd_data),
  .odd_stat    (odd_stat),
  .odd_frame   (odd_frame),
  .even_par    (even_par),
  .odd_par     (odd_par),
  .par_oe      (par_oe)
);

// File: tb/sim_rxo_pair_out.sv
`timescale 1ns/1ps
module sim_rxo_pair_out;
  logic       clk, rst_n, in_valid, in_frame, framer_en, dec_bypass, bist_active;
  logic [7:0] in_data;
  logic [2:0] in_stat;
  logic [1:0] par_mode;
  logic       out_valid, even_frame, odd_frame, even_par, odd_par, par_oe;
  logic [7:0] even_data, odd_data;
  logic [2:0] even_stat, odd_stat;
  int errs = 0;
  int checks = 0;

  rxo_pair_out u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_stat(in_stat), .in_frame(in_frame), .framer_en(framer_en),
    .dec_bypass(dec_bypass), .bist_active(bist_active), .par_mode(par_mode),
    .out_valid(out_valid), .even_data(even_data), .even_stat(even_stat),
    .even_frame(even_frame), .odd_data(odd_data), .odd_stat(odd_stat),
    .odd_frame(odd_frame), .even_par(even_par), .odd_par(odd_par), .par_oe(par_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(logic [7:0] d, logic [2:0] s, logic f);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_stat = s; in_frame = f;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; in_frame = 1'b0;
  endtask

  task automatic chk_pair(string req, logic v, logic [7:0] ed, logic ef, logic [7:0] od, logic of);
    chk(req, "out_valid", 16'(out_valid), 16'(v));
    chk(req, "even_data", 16'(even_data), 16'(ed));
    chk(req, "even_frame", 16'(even_frame), 16'(ef));
    chk(req, "odd_data", 16'(odd_data), 16'(od));
    chk(req, "odd_frame", 16'(odd_frame), 16'(of));
  endtask

  // Odd parity reference: covered ones plus parity bit must be odd
  function automatic logic ref_par(logic [7:0] d, logic [2:0] s, int m, int b);
    int n = $countones(d);
    if (m == 1) begin
      if (b != 0) n += $countones(s[1:0]);
    end else if (m == 2) begin
      n += $countones(s);
    end else begin
      return 1'b0;
    end
    return (n % 2 == 0);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "out_valid in reset", 16'(out_valid), 16'h0);
    chk("R1", "even_data in reset", 16'(even_data), 16'h0);
    chk("R1", "odd_data in reset", 16'(odd_data), 16'h0);
    chk("R1", "par_oe in reset", 16'(par_oe), 16'h0);
    rst_n = 1'b1;
    repeat (3) idle();
    chk("R1", "out_valid after release", 16'(out_valid), 16'h0);
    chk("R1", "odd_stat after release", 16'(odd_stat), 16'h0);
  endtask

  task automatic t_pairs();
    framer_en = 1'b0;
    put(8'hA1, 3'b000, 1'b0);
    put(8'hB2, 3'b000, 1'b0);
    idle();
    chk_pair("R2", 1'b1, 8'hA1, 1'b0, 8'hB2, 1'b0);
    idle();
    chk_pair("R3", 1'b0, 8'hA1, 1'b0, 8'hB2, 1'b0);
    put(8'hC3, 3'b000, 1'b0);
    idle();
    idle();
    chk_pair("R3", 1'b0, 8'hA1, 1'b0, 8'hB2, 1'b0);
    put(8'hD4, 3'b000, 1'b0);
    idle();
    chk_pair("R3", 1'b1, 8'hC3, 1'b0, 8'hD4, 1'b0);
  endtask

  task automatic t_even_frame();
    framer_en = 1'b1;
    put(8'hF0, 3'b000, 1'b1);
    put(8'h11, 3'b000, 1'b0);
    idle();
    chk_pair("R5", 1'b1, 8'hF0, 1'b1, 8'h11, 1'b0);
  endtask

  task automatic t_slip();
    framer_en = 1'b1;
    put(8'h22, 3'b000, 1'b0);
    put(8'hF1, 3'b000, 1'b1);
    idle();
    chk_pair("R4", 1'b0, 8'hF0, 1'b1, 8'h11, 1'b0);
    put(8'h33, 3'b000, 1'b0);
    idle();
    chk_pair("R4", 1'b1, 8'hF1, 1'b1, 8'h33, 1'b0);
    put(8'h44, 3'b000, 1'b0);
    put(8'h55, 3'b000, 1'b0);
    idle();
    chk_pair("R4", 1'b1, 8'h44, 1'b0, 8'h55, 1'b0);
  endtask

  task automatic t_no_align();
    framer_en = 1'b0;
    put(8'h66, 3'b000, 1'b0);
    put(8'hF2, 3'b000, 1'b1);
    idle();
    chk_pair("R6", 1'b1, 8'h66, 1'b0, 8'hF2, 1'b1);
    chk("R7", "odd_frame flag", 16'(odd_frame), 16'h1);
  endtask

  task automatic t_status();
    dec_bypass = 1'b1; bist_active = 1'b0;
    put(8'h10, 3'b111, 1'b0);
    put(8'h20, 3'b111, 1'b1);
    idle();
    chk("R8", "even_stat forced", 16'(even_stat), 16'h3);
    chk("R8", "odd_stat framing kept", 16'(odd_stat), 16'h7);
    bist_active = 1'b1;
    put(8'h30, 3'b111, 1'b0);
    put(8'h40, 3'b110, 1'b0);
    idle();
    chk("R8", "even_stat self-test", 16'(even_stat), 16'h7);
    chk("R8", "odd_stat self-test", 16'(odd_stat), 16'h6);
    dec_bypass = 1'b0; bist_active = 1'b0;
    put(8'h50, 3'b101, 1'b0);
    put(8'h60, 3'b100, 1'b0);
    idle();
    chk("R8", "even_stat decoder on", 16'(even_stat), 16'h5);
    chk("R8", "odd_stat decoder on", 16'(odd_stat), 16'h4);
  endtask

  task automatic t_parity();
    dec_bypass = 1'b0;
    put(8'h03, 3'b101, 1'b0);
    put(8'h07, 3'b010, 1'b0);
    idle();
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        string req;
        @(negedge clk);
        par_mode = 2'(m); dec_bypass = b[0];
        #1;
        if (m == 0 || m == 3) req = "R9";
        else if (m == 2) req = "R12";
        else if (b == 0) req = "R10";
        else req = "R11";
        chk(req, "par_oe", 16'(par_oe), 16'(m == 1 || m == 2));
        chk(req, "even_par", 16'(even_par), 16'(ref_par(8'h03, 3'b101, m, b)));
        chk(req, "odd_par", 16'(odd_par), 16'(ref_par(8'h07, 3'b010, m, b)));
      end
    end
    @(negedge clk);
    par_mode = 2'b00; dec_bypass = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_stat = '0; in_frame = 1'b0;
    framer_en = 1'b0; dec_bypass = 1'b0; bist_active = 1'b0; par_mode = 2'b00;
    t_reset();
    t_pairs();
    t_even_frame();
    t_slip();
    t_no_align();
    t_status();
    t_parity();
    repeat (2) idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule